// File: doc/BRIEF.md
# Shadow-Backed Flash Control Register Bank

This block is the register bank that configures an on-chip flash module. It holds a configuration word, a test word, two words that place the flash array in the address map, a control word and four read-only start-up words. Every register that matters at power-up has a non-volatile shadow copy. The shadow copies are modelled here as a register file. During reset, each live register reloads its shadow-backed fields from its shadow word. A shadow word is programmed through a separate port, using the same address as its live register. Programming a shadow word never disturbs the live register, so the new value takes effect only at the next reset.

The CPU side is a 16-bit bus with a byte address, read and write strobes, and a ready response that the block raises in the same cycle for any access to its 32-byte register window. The block also decodes the relocatable array window and drives an array-select output for accesses that land in it. That select is withheld while the module is stopped, and also wherever the register window overlaps the array. A lock bit closes the configuration word to CPU writes. The test and base words stay writable while the module is unlocked or stopped.

Top module: `flash_cfg_bank`

## Requirements
- R1: While `rst_n` is low, the shadow-backed fields take their values from their shadow words on every clock edge: the configuration fields, both base words and the four start-up words. The test and control words reset to 0.
- R2: At reset the stop bit is the OR of its shadow bit (shadow word bit 15) and the inverse of `strap_stop_n`. A low strap therefore forces stop to 1.
- R3: A shadow program at a register-window address (word index = address bits 4:1) changes only that shadow word. The live register keeps its value until the next reset.
- R4: A shadow erase sets all sixteen shadow words to `ERASED` (default 0xFFFF) and leaves the live registers untouched until the next reset.
- R5: No CPU write ever changes a shadow word. Live values written by the CPU are lost at the next reset.
- R6: The configuration word sits at word 0 and has this layout: stop at bit 15, freeze at 14, boot at 12, lock at 11, a 2-bit space field at bits 9:8, and all other bits reading 0. CPU writes to it take effect only while lock is 0.
- R7: The test word (word 1, bits 3:0) and the base words (words 2 and 3) accept CPU writes only while lock is 0 or stop is 1.
- R8: The base-high word (bits 7:0) holds address bits 23:16. The base-low word (bits 15:11) holds address bits 15:11. The array base is therefore 2 KB aligned, and lower written bits are dropped and read 0.
- R9: `array_sel` is 1 for a read or write whose address lies in [base, base + ARRAY_BYTES), provided stop is 0 and the address is outside the register window.
- R10: The register window is the 32 bytes at `CTRL_BASE`. An access there raises `bus_ready` in the same cycle with combinational read data and never raises `array_sel`, even where the array overlaps it. Outside it, `bus_ready` is 0 and `bus_rdata` is 0.
- R11: Reads of unmapped words (5 to 7 and 12 to 15) return 0 with ready. Writes to the start-up words (8 to 11) are discarded. The control word (word 4, bits 3:0) is writable at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; live registers load from shadow while low |
| strap_stop_n | input | 1 | Strap sampled during reset; low forces stop |
| bus_addr | input | AW | CPU byte address |
| bus_wdata | input | 16 | CPU write data |
| bus_rd | input | 1 | CPU read strobe |
| bus_wr | input | 1 | CPU write strobe |
| bus_rdata | output | 16 | Register read data, 0 outside the register window |
| bus_ready | output | 1 | Register-window access acknowledge |
| shd_prog | input | 1 | Program one shadow word |
| shd_erase | input | 1 | Erase all shadow words (array erase) |
| shd_addr | input | AW | Register address of the shadow word to program |
| shd_wdata | input | 16 | Shadow program data |
| array_sel | output | 1 | Access targets the flash array window |

## Verification
The embedded properties hold on every cycle. They check that a locked configuration word and locked base words keep their values across write attempts, that a shadow program leaves the live configuration and base untouched, that the shadow file changes only through its own port, and that ready and array-select are never active together. Only the bench scenarios can show the effects that span a reset: shadow values appearing after reset, the strap forcing stop, an erase producing an all-ones configuration, and CPU writes vanishing. The bench scenarios also cover the exact window edges and the bit masking of each word.

// File: rtl/fcb_pkg.sv
package fcb_pkg;
  localparam int WORD_W    = 16;
  localparam int OFF_W     = 4;
  localparam int SHD_WORDS = 1 << OFF_W;
  localparam int BLK_LSB   = OFF_W + 1;
  localparam int VEC_WORDS = 4;
  localparam int TST_W     = 4;
  localparam int CTL_W     = 4;

  localparam logic [OFF_W-1:0] OFF_CFG = 4'd0;
  localparam logic [OFF_W-1:0] OFF_TST = 4'd1;
  localparam logic [OFF_W-1:0] OFF_BHI = 4'd2;
  localparam logic [OFF_W-1:0] OFF_BLO = 4'd3;
  localparam logic [OFF_W-1:0] OFF_CTL = 4'd4;
  localparam logic [OFF_W-1:0] OFF_VEC = 4'd8;

  localparam int P_STOP = 15;
  localparam int P_FRZ  = 14;
  localparam int P_BOOT = 12;
  localparam int P_LOCK = 11;
  localparam int P_SPC  = 8;

  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    logic       stop;
    logic       frz;
    logic       boot;
    logic       lock;
    logic [1:0] spc;
  } cfg_t;

  function automatic cfg_t cfg_from_word(word_t w);
    cfg_t c;
    c.stop = w[P_STOP];
    c.frz  = w[P_FRZ];
    c.boot = w[P_BOOT];
    c.lock = w[P_LOCK];
    c.spc  = w[P_SPC +: 2];
    return c;
  endfunction

  function automatic word_t cfg_to_word(cfg_t c);
    word_t w;
    w = '0;
    w[P_STOP]     = c.stop;
    w[P_FRZ]      = c.frz;
    w[P_BOOT]     = c.boot;
    w[P_LOCK]     = c.lock;
    w[P_SPC +: 2] = c.spc;
    return w;
  endfunction

  function automatic logic is_vec_off(logic [OFF_W-1:0] o);
    return (o >= OFF_VEC) && (o < OFF_VEC + 4'(VEC_WORDS));
  endfunction
endpackage

// File: rtl/fcb_shadow_store.sv
module fcb_shadow_store
  import fcb_pkg::*;
#(
  parameter word_t ERASED = 16'hFFFF
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              prog,
  input  logic                              erase,
  input  logic [OFF_W-1:0]                  idx,
  input  word_t                             wdata,
  output logic [SHD_WORDS-1:0][WORD_W-1:0]  words
);
  // Non-volatile model: no reset, changed only by program or erase.
  always_ff @(posedge clk) begin
    if (erase)
      words <= {SHD_WORDS{ERASED}};
    else if (prog)
      words[idx] <= wdata;
  end

  // R5: nothing but the shadow port alters the shadow file
  assert_shadow_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(prog || erase) |=> $stable(words));
endmodule

// File: rtl/fcb_addr_decode.sv
module fcb_addr_decode
  import fcb_pkg::*;
#(
  parameter int             AW          = 24,
  parameter logic [AW-1:0]  CTRL_BASE   = 24'hFFF7A0,
  parameter int             ARRAY_BYTES = 16384
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [AW-1:0]     shd_addr,
  input  logic [AW-1:0]     array_base,
  input  logic              stop,
  output logic              reg_acc,
  output logic              reg_wr,
  output logic [OFF_W-1:0]  reg_off,
  output logic              shd_hit,
  output logic [OFF_W-1:0]  shd_off,
  output logic              array_sel
);
  localparam logic [AW:0] SPAN = (AW+1)'(ARRAY_BYTES);

  function automatic logic in_ctrl(logic [AW-1:0] a);
    return a[AW-1:BLK_LSB] == CTRL_BASE[AW-1:BLK_LSB];
  endfunction

  function automatic logic in_array(logic [AW-1:0] a, logic [AW-1:0] b);
    logic [AW:0] lo, hi, ext;
    lo  = {1'b0, b};
    hi  = lo + SPAN;
    ext = {1'b0, a};
    return (ext >= lo) && (ext < hi);
  endfunction

  logic bus_act, ctrl_hit, win_hit;
  logic addr_unused;

  assign bus_act   = bus_rd | bus_wr;
  assign ctrl_hit  = in_ctrl(bus_addr);
  assign win_hit   = in_array(bus_addr, array_base);
  assign reg_acc   = bus_act & ctrl_hit;
  assign reg_wr    = bus_wr & ctrl_hit;
  assign reg_off   = bus_addr[OFF_W:1];
  assign shd_hit   = in_ctrl(shd_addr);
  assign shd_off   = shd_addr[OFF_W:1];
  assign array_sel = bus_act & win_hit & ~stop & ~ctrl_hit;
  assign addr_unused = bus_addr[0] ^ shd_addr[0];

  // R9: a stopped module never selects the array (stop comes from the live regs)
  assert_sel_stopped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop |-> !array_sel);
endmodule

// File: rtl/fcb_live_regs.sv
module fcb_live_regs
  import fcb_pkg::*;
#(
  parameter int AW    = 24,
  parameter int ALIGN = 11
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              strap_stop_n,
  input  logic [SHD_WORDS-1:0][WORD_W-1:0]  shd,
  input  logic                              reg_acc,
  input  logic                              reg_wr,
  input  logic [OFF_W-1:0]                  reg_off,
  input  word_t                             wdata,
  output word_t                             rdata,
  output logic                              ready,
  output logic [AW-1:0]                     array_base,
  output word_t                             cfg_word,
  output logic                              stop
);
  localparam int HI_W = AW - 16;
  localparam int LO_W = 16 - ALIGN;

  cfg_t                                cfg_q, cfg_rst;
  logic [TST_W-1:0]                    tst_q;
  logic [HI_W-1:0]                     bhi_q;
  logic [LO_W-1:0]                     blo_q;
  logic [CTL_W-1:0]                    ctl_q;
  logic [VEC_WORDS-1:0][WORD_W-1:0]    vec_q;
  word_t                               rd_word;
  logic                                wr_cfg_try, wr_tst_try, wr_bhi_try, wr_blo_try, wr_ctl_try;
  logic                                cfg_open, aux_open;
  logic                                bits_unused;

  assign wr_cfg_try = reg_wr & (reg_off == OFF_CFG);
  assign wr_tst_try = reg_wr & (reg_off == OFF_TST);
  assign wr_bhi_try = reg_wr & (reg_off == OFF_BHI);
  assign wr_blo_try = reg_wr & (reg_off == OFF_BLO);
  assign wr_ctl_try = reg_wr & (reg_off == OFF_CTL);
  assign cfg_open   = ~cfg_q.lock;
  assign aux_open   = ~cfg_q.lock | cfg_q.stop;

  always_comb begin
    cfg_rst      = cfg_from_word(shd[OFF_CFG]);
    cfg_rst.stop = shd[OFF_CFG][P_STOP] | ~strap_stop_n;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= cfg_rst;
      tst_q <= '0;
      bhi_q <= shd[OFF_BHI][HI_W-1:0];
      blo_q <= shd[OFF_BLO][WORD_W-1:ALIGN];
      ctl_q <= '0;
      for (int i = 0; i < VEC_WORDS; i++)
        vec_q[i] <= shd[int'(OFF_VEC) + i];
    end else begin
      if (wr_cfg_try && cfg_open) cfg_q <= cfg_from_word(wdata);
      if (wr_tst_try && aux_open) tst_q <= wdata[TST_W-1:0];
      if (wr_bhi_try && aux_open) bhi_q <= wdata[HI_W-1:0];
      if (wr_blo_try && aux_open) blo_q <= wdata[WORD_W-1:ALIGN];
      if (wr_ctl_try)             ctl_q <= wdata[CTL_W-1:0];
    end
  end

  always_comb begin
    rd_word = '0;
    case (reg_off)
      OFF_CFG: rd_word = cfg_to_word(cfg_q);
      OFF_TST: rd_word[TST_W-1:0] = tst_q;
      OFF_BHI: rd_word[HI_W-1:0] = bhi_q;
      OFF_BLO: rd_word[WORD_W-1:ALIGN] = blo_q;
      OFF_CTL: rd_word[CTL_W-1:0] = ctl_q;
      default: if (is_vec_off(reg_off)) rd_word = vec_q[reg_off[1:0]];
    endcase
  end

  assign rdata       = reg_acc ? rd_word : '0;
  assign ready       = reg_acc;
  assign array_base  = {bhi_q, blo_q, {ALIGN{1'b0}}};
  assign cfg_word    = cfg_to_word(cfg_q);
  assign stop        = cfg_q.stop;
  assign bits_unused = ^{wdata, shd};

  // R6: a write attempt against a locked configuration word changes nothing
  assert_cfg_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cfg_try && cfg_q.lock) |=> $stable(cfg_q));

  // R7: base words hold while locked and running
  assert_base_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_bhi_try || wr_blo_try) && cfg_q.lock && !cfg_q.stop) |=> $stable(array_base));
endmodule

// File: rtl/flash_cfg_bank.sv
module flash_cfg_bank
  import fcb_pkg::*;
#(
  parameter int             AW          = 24,
  parameter logic [AW-1:0]  CTRL_BASE   = 24'hFFF7A0,
  parameter int             ARRAY_BYTES = 16384,
  parameter int             ALIGN       = 11,
  parameter logic [15:0]    ERASED      = 16'hFFFF
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           strap_stop_n,
  input  logic [AW-1:0]  bus_addr,
  input  logic [15:0]    bus_wdata,
  input  logic           bus_rd,
  input  logic           bus_wr,
  output logic [15:0]    bus_rdata,
  output logic           bus_ready,
  input  logic           shd_prog,
  input  logic           shd_erase,
  input  logic [AW-1:0]  shd_addr,
  input  logic [15:0]    shd_wdata,
  output logic           array_sel
);
  logic [SHD_WORDS-1:0][WORD_W-1:0] shd_words;
  logic                             reg_acc, reg_wr, shd_hit, stop;
  logic [OFF_W-1:0]                 reg_off, shd_off;
  logic [AW-1:0]                    array_base;
  word_t                            cfg_word;

  fcb_shadow_store #(.ERASED(ERASED)) u_shadow (
    .clk   (clk),
    .rst_n (rst_n),
    .prog  (shd_prog & shd_hit),
    .erase (shd_erase),
    .idx   (shd_off),
    .wdata (shd_wdata),
    .words (shd_words)
  );

  fcb_addr_decode #(.AW(AW), .CTRL_BASE(CTRL_BASE), .ARRAY_BYTES(ARRAY_BYTES)) u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .shd_addr   (shd_addr),
    .array_base (array_base),
    .stop       (stop),
    .reg_acc    (reg_acc),
    .reg_wr     (reg_wr),
    .reg_off    (reg_off),
    .shd_hit    (shd_hit),
    .shd_off    (shd_off),
    .array_sel  (array_sel)
  );

  fcb_live_regs #(.AW(AW), .ALIGN(ALIGN)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .strap_stop_n (strap_stop_n),
    .shd          (shd_words),
    .reg_acc      (reg_acc),
    .reg_wr       (reg_wr),
    .reg_off      (reg_off),
    .wdata        (bus_wdata),
    .rdata        (bus_rdata),
    .ready        (bus_ready),
    .array_base   (array_base),
    .cfg_word     (cfg_word),
    .stop         (stop)
  );

  // R10: register window and array window never answer the same access
  assert_no_dual_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_ready && array_sel));

  // R3: shadow programming leaves live configuration and base untouched
  assert_prog_isolated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (shd_prog && !bus_wr) |=> ($stable(cfg_word) && $stable(array_base)));
endmodule

// File: tb/flash_cfg_bank_test.sv
module flash_cfg_bank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap_stop_n = 1'b1;
  logic [23:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [15:0] bus_rdata;
  logic        bus_ready;
  logic        shd_prog = 1'b0, shd_erase = 1'b0;
  logic [23:0] shd_addr = '0;
  logic [15:0] shd_wdata = '0;
  logic        array_sel;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  flash_cfg_bank uut (
    .clk(clk), .rst_n(rst_n), .strap_stop_n(strap_stop_n),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_rdata(bus_rdata), .bus_ready(bus_ready),
    .shd_prog(shd_prog), .shd_erase(shd_erase), .shd_addr(shd_addr), .shd_wdata(shd_wdata),
    .array_sel(array_sel)
  );

  localparam logic [1:0] OP_RD = 2'd0, OP_WR = 2'd1, OP_SP = 2'd2;
  localparam logic [23:0] A_CFG = 24'hFFF7A0, A_TST = 24'hFFF7A2, A_BHI = 24'hFFF7A4,
                          A_BLO = 24'hFFF7A6, A_CTL = 24'hFFF7A8, A_V0 = 24'hFFF7B0,
                          A_V3 = 24'hFFF7B6;

  typedef struct packed {
    logic [1:0]  op;
    logic [23:0] addr;
    logic [15:0] wd;
    logic [15:0] exp;
    logic        rdy;
    logic        sel;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t TBL [NV] = '{
    '{OP_RD, 24'h018000, 16'h0000, 16'h0000, 1'b0, 1'b1, 4'd9},  // R9 first byte
    '{OP_RD, 24'h01BFFE, 16'h0000, 16'h0000, 1'b0, 1'b1, 4'd9},  // R9 last word
    '{OP_RD, 24'h01C000, 16'h0000, 16'h0000, 1'b0, 1'b0, 4'd9},  // R9 one past end
    '{OP_RD, 24'h017FFE, 16'h0000, 16'h0000, 1'b0, 1'b0, 4'd9},  // R9 below base
    '{OP_RD, 24'hFFF7AA, 16'h0000, 16'h0000, 1'b1, 1'b0, 4'd11}, // R11 unmapped
    '{OP_WR, A_TST,      16'hFFFF, 16'h0000, 1'b0, 1'b0, 4'd7},
    '{OP_RD, A_TST,      16'h0000, 16'h000F, 1'b1, 1'b0, 4'd7},  // R7 unlocked
    '{OP_WR, A_V0,       16'h0000, 16'h0000, 1'b0, 1'b0, 4'd11},
    '{OP_RD, A_V0,       16'h0000, 16'h1234, 1'b1, 1'b0, 4'd11}, // R11 start-up word kept
    '{OP_WR, A_BHI,      16'hFFFF, 16'h0000, 1'b0, 1'b0, 4'd8},
    '{OP_WR, A_BLO,      16'hF7FF, 16'h0000, 1'b0, 1'b0, 4'd8},
    '{OP_RD, A_BLO,      16'h0000, 16'hF000, 1'b1, 1'b0, 4'd8},  // R8 low bits dropped
    '{OP_RD, A_BHI,      16'h0000, 16'h00FF, 1'b1, 1'b0, 4'd8},
    '{OP_RD, 24'hFFF000, 16'h0000, 16'h0000, 1'b0, 1'b1, 4'd8},  // R8 new base
    '{OP_RD, A_CFG,      16'h0000, 16'h4100, 1'b1, 1'b0, 4'd10}, // R10 overlap: regs win
    '{OP_RD, 24'hFFF7C0, 16'h0000, 16'h0000, 1'b0, 1'b1, 4'd10}, // R10 just past window
    '{OP_WR, A_CFG,      16'hFFFF, 16'h0000, 1'b0, 1'b0, 4'd6},
    '{OP_RD, A_CFG,      16'h0000, 16'hDB00, 1'b1, 1'b0, 4'd6},  // R6 layout
    '{OP_RD, 24'hFFF000, 16'h0000, 16'h0000, 1'b0, 1'b0, 4'd9},  // R9 stopped
    '{OP_WR, A_CFG,      16'h0000, 16'h0000, 1'b0, 1'b0, 4'd6},
    '{OP_RD, A_CFG,      16'h0000, 16'hDB00, 1'b1, 1'b0, 4'd6},  // R6 locked
    '{OP_WR, A_BLO,      16'h0800, 16'h0000, 1'b0, 1'b0, 4'd7},
    '{OP_RD, A_BLO,      16'h0000, 16'h0800, 1'b1, 1'b0, 4'd7},  // R7 locked but stopped
    '{OP_WR, A_TST,      16'h0005, 16'h0000, 1'b0, 1'b0, 4'd7},
    '{OP_RD, A_TST,      16'h0000, 16'h0005, 1'b1, 1'b0, 4'd7},
    '{OP_WR, A_CTL,      16'hFFFF, 16'h0000, 1'b0, 1'b0, 4'd11},
    '{OP_RD, A_CTL,      16'h0000, 16'h000F, 1'b1, 1'b0, 4'd11},
    '{OP_SP, A_CFG,      16'h0800, 16'h0000, 1'b0, 1'b0, 4'd3},
    '{OP_RD, A_CFG,      16'h0000, 16'hDB00, 1'b1, 1'b0, 4'd3}   // R3 live unchanged
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One bus or shadow operation; obs = {ready, sel, rdata} sampled before the edge.
  task automatic do_op(input logic [1:0] op, input logic [23:0] a, input logic [15:0] d,
                       output logic [17:0] obs);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; shd_addr = a; shd_wdata = d;
    bus_rd = (op == OP_RD); bus_wr = (op == OP_WR); shd_prog = (op == OP_SP);
    #1 obs = {bus_ready, array_sel, bus_rdata};
    @(posedge clk);
    #1 bus_rd = 0; bus_wr = 0; shd_prog = 0;
  endtask

  task automatic rd_reg(input logic [23:0] a, input logic [15:0] exp, input string req);
    logic [17:0] o;
    do_op(OP_RD, a, 16'h0, o);
    check(req, 32'(o), {14'h0, 2'b10, exp});
  endtask

  task automatic rd_arr(input logic [23:0] a, input logic sel, input string req);
    logic [17:0] o;
    do_op(OP_RD, a, 16'h0, o);
    check(req, 32'(o), {14'h0, 1'b0, sel, 16'h0});
  endtask

  task automatic wr(input logic [23:0] a, input logic [15:0] d);
    logic [17:0] o;
    do_op(OP_WR, a, d, o);
  endtask

  task automatic sprog(input logic [23:0] a, input logic [15:0] d);
    logic [17:0] o;
    do_op(OP_SP, a, d, o);
  endtask

  task automatic serase();
    @(negedge clk); shd_erase = 1;
    @(posedge clk); #1 shd_erase = 0;
  endtask

  task automatic do_reset(input logic strap);
    @(negedge clk); rst_n = 0; strap_stop_n = strap;
    repeat (3) @(negedge clk);
    rst_n = 1; strap_stop_n = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [17:0] o;
    // Shadow setup while held in reset
    serase();
    sprog(A_CFG, 16'h4100);
    sprog(A_BHI, 16'h0001);
    sprog(A_BLO, 16'h8000);
    sprog(A_V0,  16'h1234);
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state from shadow
    rd_reg(A_CFG, 16'h4100, "R1 cfg");
    rd_reg(A_TST, 16'h0000, "R1 tst");
    rd_reg(A_BHI, 16'h0001, "R1 base hi");
    rd_reg(A_BLO, 16'h8000, "R1 base lo");
    rd_reg(A_CTL, 16'h0000, "R1 ctl");
    rd_reg(A_V0,  16'h1234, "R1 vec0");
    rd_reg(24'hFFF7B2, 16'hFFFF, "R1 vec1");

    for (int i = 0; i < NV; i++) begin
      do_op(TBL[i].op, TBL[i].addr, TBL[i].wd, o);
      if (TBL[i].op == OP_RD)
        check($sformatf("R%0d vec %0d", TBL[i].req, i), 32'(o),
              {14'h0, TBL[i].rdy, TBL[i].sel, TBL[i].exp});
    end

    // Reset picks up the new shadow config; CPU writes did not reach the shadows
    do_reset(1'b1);
    rd_reg(A_CFG, 16'h0800, "R3 shadow now live");
    rd_reg(A_BHI, 16'h0001, "R5 base hi shadow kept");
    rd_reg(A_BLO, 16'h8000, "R5 base lo shadow kept");
    rd_reg(A_TST, 16'h0000, "R1 tst fixed");
    rd_reg(A_CTL, 16'h0000, "R1 ctl fixed");
    wr(A_BHI, 16'h0055);
    rd_reg(A_BHI, 16'h0001, "R7 base locked");
    wr(A_TST, 16'h000F);
    rd_reg(A_TST, 16'h0000, "R7 tst locked");
    wr(A_CFG, 16'h0000);
    rd_reg(A_CFG, 16'h0800, "R6 cfg locked");
    wr(A_CTL, 16'h0005);
    rd_reg(A_CTL, 16'h0005, "R11 ctl always writable");
    rd_arr(24'h018000, 1'b1, "R9 running select");
    rd_arr(24'h01BFFF, 1'b1, "R9 last byte");

    // Strap forces stop
    do_reset(1'b0);
    rd_reg(A_CFG, 16'h8800, "R2 strap stop");
    rd_arr(24'h018000, 1'b0, "R2 stopped no select");

    // Erase: live unchanged until reset, then all-ones shadow applies
    serase();
    rd_reg(A_CFG, 16'h8800, "R4 live kept after erase");
    rd_reg(A_V0, 16'h1234, "R4 vec kept after erase");
    do_reset(1'b1);
    rd_reg(A_CFG, 16'hDB00, "R4 erased cfg");
    rd_reg(A_BHI, 16'h00FF, "R4 erased base hi");
    rd_reg(A_BLO, 16'hF800, "R4 erased base lo");
    rd_reg(A_V3,  16'hFFFF, "R4 erased vec3");
    rd_reg(A_TST, 16'h0000, "R1 tst after erase");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule